// File: doc/BRIEF.md
# UART Transmit Flow Gate with RTS Steering and Remote Loopback

This block sits between a UART core and its serial pins. It decides whether the UART may start the next transmit character. A six-bit enable mask chooses which conditions can hold transmission off: four modem status inputs (clear-to-send, carrier detect, data-set-ready and ring), a software transmit enable, and a flag from receive-side character flow control. When any selected condition is deasserted, the transmit permission is withdrawn. The permission changes only between characters, so a character that has already started is always sent in full.

The block also drives the RTS pin. In direct mode the pin follows the UART's own request. In automatic mode the pin drops while the receive FIFO holds half its depth or more, and it rises again once the level falls below half. A remote loopback setting sends the incoming serial line straight back out of the transmit pin and blocks the UART's own transmit data.

The modem inputs are asynchronous and pass through two-flop synchronisers before they are used. The settings are loaded through a single write strobe.

Top module: `flowgate`

## Requirements
- R1: While reset is asserted, txPermit is 0, the enable mask is 6'b010000, and automatic RTS and remote loopback are off. With uartTxBusy low, txPermit is 1 on the first clock after reset is released.
- R2: A cycle with cfgWrEn high loads cfgWrData[5:0] into the enable mask, cfgWrData[6] into the automatic-RTS setting and cfgWrData[7] into the remote-loopback setting. The new values are in effect from the next clock.
- R3: Mask bit 4 is the software transmit enable. When it is 0, txPermit becomes 0 at the next clock on which uartTxBusy is low, whatever the other inputs are.
- R4: Mask bits 0, 1, 2 and 3 select ctsIn, dcdIn, dsrIn and riIn. A selected line that is low (deasserted) removes the permission. A line whose mask bit is 0 has no effect on txPermit.
- R5: A change on a modem input reaches txPermit on the third rising clock edge after the change, because it passes two synchroniser stages and the permission register.
- R6: Mask bit 5 selects rxCharFlowOk, which is used without synchronisation. When the bit is set and the flag is low, txPermit is 0 after the next clock on which uartTxBusy is low.
- R7: While uartTxBusy is high, txPermit keeps its value, so a character that has started always completes.
- R8: With automatic RTS off, rtsOut equals uartRtsReq.
- R9: With automatic RTS on, rtsOut is 0 when rxFifoLevel >= FIFO_DEPTH/2 and 1 when it is below that. The default FIFO_DEPTH is 64.
- R10: With remote loopback on, txdOut equals rxdIn and uartTxd is ignored. With it off, txdOut equals uartTxd. uartRxd always equals rxdIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Load strobe for the settings |
| cfgWrData | input | 8 | [5:0] mask, [6] automatic RTS, [7] remote loopback |
| ctsIn | input | 1 | Clear-to-send, asynchronous, 1 = asserted |
| dcdIn | input | 1 | Carrier detect, asynchronous, 1 = asserted |
| dsrIn | input | 1 | Data-set-ready, asynchronous, 1 = asserted |
| riIn | input | 1 | Ring indicator, asynchronous, 1 = asserted |
| rxCharFlowOk | input | 1 | Receive character flow flag, 1 = transmit allowed |
| uartTxBusy | input | 1 | UART is sending a character |
| txPermit | output | 1 | UART may start the next character |
| uartRtsReq | input | 1 | RTS request from the UART |
| rxFifoLevel | input | LEVEL_W (7) | Receive FIFO fill level |
| rtsOut | output | 1 | RTS pin, 1 = asserted |
| uartTxd | input | 1 | Serial transmit data from the UART |
| rxdIn | input | 1 | Serial receive line from the pin |
| txdOut | output | 1 | Serial transmit pin |
| uartRxd | output | 1 | Serial receive data to the UART |

## Verification
Two events can fall in the same cycle: a condition withdraws the permission while uartTxBusy is high, or a settings write changes the mask on the same edge where a synchronised modem line changes. The bench drives uartTxBusy, the modem lines and cfgWrEn independently, with a bias toward overlap. It judges each edge against a reference model built from history queues, which applies the hold rule before the mask update. Automatic RTS is also tested at FIFO levels just below and exactly at the half-full point, both with and without remote loopback.

// File: rtl/flowgate_pkg.sv
package flowgate_pkg;
  localparam int MASK_W      = 6;
  localparam int MODEM_LINES = 4;
  localparam int CFG_W       = MASK_W + 2;
  localparam int SW_BIT      = 4;
  localparam int CHAR_BIT    = 5;
  localparam int AUTO_BIT    = 6;
  localparam int LOOP_BIT    = 7;
  localparam logic [MASK_W-1:0] MASK_RESET = 6'b010000;

  typedef struct packed {
    logic rtsAuto;
    logic remoteLoop;
  } dpStrobes_t;
endpackage

// File: rtl/flowgate_ctrl.sv
module flowgate_ctrl
  import flowgate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfgWrEn,
  input  logic [CFG_W-1:0]       cfgWrData,
  input  logic [MODEM_LINES-1:0] modemIn,
  input  logic                   rxCharFlowOk,
  input  logic                   uartTxBusy,
  output logic                   txPermit,
  output dpStrobes_t             strobes
);
  logic [MASK_W-1:0]      cfgMask;
  logic                   cfgAuto;
  logic                   cfgLoop;
  logic [MODEM_LINES-1:0] modemSync;
  logic [MODEM_LINES-1:0] modemBlock;
  logic                   gateOk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgMask <= MASK_RESET;
      cfgAuto <= 1'b0;
      cfgLoop <= 1'b0;
    end else if (cfgWrEn) begin
      cfgMask <= cfgWrData[MASK_W-1:0];
      cfgAuto <= cfgWrData[AUTO_BIT];
      cfgLoop <= cfgWrData[LOOP_BIT];
    end
  end

  genvar g;
  generate
    for (g = 0; g < MODEM_LINES; g++) begin : gSync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-2:0], modemIn[g]};
      end
      assign modemSync[g]  = chain[SYNC_STAGES-1];
      assign modemBlock[g] = cfgMask[g] & ~modemSync[g];
    end
  endgenerate

  always_comb begin
    gateOk = cfgMask[SW_BIT];
    if (|modemBlock) gateOk = 1'b0;
    if (cfgMask[CHAR_BIT] && !rxCharFlowOk) gateOk = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           txPermit <= 1'b0;
    else if (!uartTxBusy) txPermit <= gateOk;
  end

  assign strobes.rtsAuto    = cfgAuto;
  assign strobes.remoteLoop = cfgLoop;

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uartTxBusy |=> $stable(txPermit));

  // R3
  sw_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfgMask[SW_BIT] && !uartTxBusy) |=> !txPermit);

  // R4
  modem_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgMask[0] && !modemSync[0] && !uartTxBusy) |=> !txPermit);

  // R6
  char_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgMask[CHAR_BIT] && !rxCharFlowOk && !uartTxBusy) |=> !txPermit);
endmodule

// File: rtl/flowgate_dp.sv
module flowgate_dp
  import flowgate_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int LEVEL_W    = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dpStrobes_t         strobes,
  input  logic [LEVEL_W-1:0] rxFifoLevel,
  input  logic               uartRtsReq,
  input  logic               uartTxd,
  input  logic               rxdIn,
  output logic               rtsOut,
  output logic               txdOut,
  output logic               uartRxd
);
  localparam logic [LEVEL_W-1:0] HALF_LEVEL = LEVEL_W'(FIFO_DEPTH / 2);

  logic fifoHalf;
  assign fifoHalf = (rxFifoLevel >= HALF_LEVEL);

  always_comb begin
    if (strobes.rtsAuto) rtsOut = ~fifoHalf;
    else                 rtsOut = uartRtsReq;
  end

  always_comb begin
    if (strobes.remoteLoop) txdOut = rxdIn;
    else                    txdOut = uartTxd;
  end

  assign uartRxd = rxdIn;

  // R9
  rts_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.rtsAuto && rxFifoLevel >= HALF_LEVEL) |-> !rtsOut);

  // R10
  loop_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.remoteLoop |-> (txdOut == uartRxd));
endmodule

// File: rtl/flowgate.sv
module flowgate
  import flowgate_pkg::*;
#(
  parameter int FIFO_DEPTH  = 64,
  parameter int LEVEL_W     = $clog2(FIFO_DEPTH + 1),
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgWrEn,
  input  logic [7:0]         cfgWrData,
  input  logic               ctsIn,
  input  logic               dcdIn,
  input  logic               dsrIn,
  input  logic               riIn,
  input  logic               rxCharFlowOk,
  input  logic               uartTxBusy,
  output logic               txPermit,
  input  logic               uartRtsReq,
  input  logic [LEVEL_W-1:0] rxFifoLevel,
  output logic               rtsOut,
  input  logic               uartTxd,
  input  logic               rxdIn,
  output logic               txdOut,
  output logic               uartRxd
);
  dpStrobes_t strobes;

  flowgate_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfgWrEn      (cfgWrEn),
    .cfgWrData    (cfgWrData),
    .modemIn      ({riIn, dsrIn, dcdIn, ctsIn}),
    .rxCharFlowOk (rxCharFlowOk),
    .uartTxBusy   (uartTxBusy),
    .txPermit     (txPermit),
    .strobes      (strobes)
  );

  flowgate_dp #(.FIFO_DEPTH(FIFO_DEPTH), .LEVEL_W(LEVEL_W)) i_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .rxFifoLevel (rxFifoLevel),
    .uartRtsReq  (uartRtsReq),
    .uartTxd     (uartTxd),
    .rxdIn       (rxdIn),
    .rtsOut      (rtsOut),
    .txdOut      (txdOut),
    .uartRxd     (uartRxd)
  );
endmodule

// File: tb/test_flowgate.sv
module test_flowgate;
  localparam int DEPTH = 64;
  localparam int LW    = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic ctsIn = 1'b0, dcdIn = 1'b0, dsrIn = 1'b0, riIn = 1'b0;
  logic rxCharFlowOk = 1'b1, uartTxBusy = 1'b0, uartRtsReq = 1'b0;
  logic [LW-1:0] rxFifoLevel = '0;
  logic uartTxd = 1'b1, rxdIn = 1'b1;
  logic txPermit, rtsOut, txdOut, uartRxd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  flowgate i_flowgate (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .ctsIn(ctsIn), .dcdIn(dcdIn), .dsrIn(dsrIn), .riIn(riIn),
    .rxCharFlowOk(rxCharFlowOk), .uartTxBusy(uartTxBusy), .txPermit(txPermit),
    .uartRtsReq(uartRtsReq), .rxFifoLevel(rxFifoLevel), .rtsOut(rtsOut),
    .uartTxd(uartTxd), .rxdIn(rxdIn), .txdOut(txdOut), .uartRxd(uartRxd)
  );

  // reference model state
  logic [3:0] lineHist[$];
  logic [5:0] mMask;
  logic       mAuto, mLoop, mPermit;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      lineHist = {4'b0, 4'b0};
      mMask = 6'b010000; mAuto = 1'b0; mLoop = 1'b0; mPermit = 1'b0;
    end else begin
      logic ok;
      ok = mMask[4];                                   // R3
      for (int i = 0; i < 4; i++)
        if (mMask[i] && !lineHist[1][i]) ok = 1'b0;    // R4, R5
      if (mMask[5] && !rxCharFlowOk) ok = 1'b0;        // R6
      if (!uartTxBusy) mPermit = ok;                   // R7
      lineHist.push_front({riIn, dsrIn, dcdIn, ctsIn});
      void'(lineHist.pop_back());
      if (cfgWrEn) begin                               // R2
        mMask = cfgWrData[5:0]; mAuto = cfgWrData[6]; mLoop = cfgWrData[7];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1 R2 R3 R4 R5 R6 R7 permit", txPermit, mPermit);
      check("R8 R9 rts", rtsOut, mAuto ? (int'(rxFifoLevel) < DEPTH/2) : uartRtsReq);
      check("R10 txd", txdOut, mLoop ? rxdIn : uartTxd);
      check("R10 rxd", uartRxd, rxdIn);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic writeCfg(input logic [7:0] d);
    step(); cfgWrEn = 1'b1; cfgWrData = d;
    step(); cfgWrEn = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1; checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    uartRtsReq = 1'b1; uartTxd = 1'b0; rxdIn = 1'b1;
    #1;
    check("R1 reset permit", txPermit, 1'b0);
    check("R1 reset rts direct", rtsOut, 1'b1);
    check("R1 reset loop off", txdOut, 1'b0);
    rst_n = 1'b1;
    step(); #1;
    check("R1 permit after reset", txPermit, 1'b1);

    // R5: CTS only, latency of three edges
    writeCfg(8'b0001_0001);
    ctsIn = 1'b0; repeat (4) step();
    ctsIn = 1'b1; step(); #1;
    check("R5 edge1", txPermit, 1'b0);
    step(); #1; check("R5 edge2", txPermit, 1'b0);
    step(); #1; check("R5 edge3", txPermit, 1'b1);

    // R4: unselected line has no effect
    dcdIn = 1'b0; repeat (4) step(); #1;
    check("R4 unselected dcd", txPermit, 1'b1);

    // R7: busy holds permission
    uartTxBusy = 1'b1; ctsIn = 1'b0; repeat (5) step(); #1;
    check("R7 held while busy", txPermit, 1'b1);
    uartTxBusy = 1'b0; step(); #1;
    check("R7 drop after busy", txPermit, 1'b0);

    // R3: software disable
    ctsIn = 1'b1; writeCfg(8'b0000_0000); step(); #1;
    check("R3 sw off", txPermit, 1'b0);

    // R6: character flow flag
    writeCfg(8'b0011_0000); rxCharFlowOk = 1'b0; step(); #1;
    check("R6 char flag low", txPermit, 1'b0);
    rxCharFlowOk = 1'b1; step(); #1;
    check("R6 char flag high", txPermit, 1'b1);

    // R9 with R10 loopback
    writeCfg(8'b1101_0000);
    rxFifoLevel = LW'(DEPTH/2 - 1); #1;
    check("R9 below half", rtsOut, 1'b1);
    rxFifoLevel = LW'(DEPTH/2); #1;
    check("R9 at half", rtsOut, 1'b0);
    uartTxd = 1'b1; rxdIn = 1'b0; #1;
    check("R10 loop", txdOut, 1'b0);

    // randomised overlap phase
    for (int n = 0; n < 3000; n++) begin
      step();
      ctsIn = ($urandom % 4) != 0; dcdIn = ($urandom % 4) != 0;
      dsrIn = ($urandom % 4) != 0; riIn  = ($urandom % 4) != 0;
      rxCharFlowOk = ($urandom % 4) != 0;
      uartTxBusy = ($urandom % 3) == 0;
      uartRtsReq = $urandom; uartTxd = $urandom; rxdIn = $urandom;
      rxFifoLevel = ($urandom % 2) ? LW'(DEPTH/2 - 1 + $urandom % 2) : LW'($urandom % (DEPTH + 1));
      cfgWrEn = ($urandom % 10) == 0;
      cfgWrData = $urandom;
      if ($urandom % 4 != 0) cfgWrData[4] = 1'b1;
    end
    step(); cfgWrEn = 1'b0;
    step(); #1;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule